// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO

This block is a single-clock FIFO controller with an 18-bit data path. It stores words in an inferred register array, and it presents them through a registered output stage. A strap input is sampled during master reset. It puts the FIFO into one of two read behaviours until the next master reset. In standard mode a word is delivered only on request, one clock after the read strobe. In fall-through mode the head word moves to the outputs by itself, and the strobe acknowledges it.

The meaning of the two status outputs depends on the mode. In standard mode they are a full flag and an empty flag. In fall-through mode they are a space-available indication and a data-valid indication. A partial reset empties the FIFO without touching the strapped mode. A rewind command replays everything written since the last reset, starting again from array location zero. This is useful when a consumer must see a packet a second time.

Top module: `dual_mode_fifo`

## Requirements
- R1: While `mrst` is high at a clock edge, both pointers return to zero and `rd_data` becomes all zeros. After that edge, a standard-mode FIFO shows `rd_stat`=1 and `wr_stat`=0. A fall-through FIFO shows `rd_stat`=0 and `wr_stat`=1.
- R2: The read mode is taken from `mode_sel` on each edge where `mrst` is high (1 = fall-through, 0 = standard). It is held unchanged while `mrst` is low.
- R3: An edge with `prst` high empties the FIFO and sets `rd_data` to zero, but it keeps the mode chosen at the last master reset.
- R4: In standard mode, `wr_stat`=1 exactly when DEPTH words are held, and `rd_stat`=1 exactly when no word is held.
- R5: In standard mode, an accepted read loads the oldest word into `rd_data` at the edge that samples `rd_en`, so it is visible one clock after the strobe. Without a read, `rd_data` keeps its value.
- R6: In fall-through mode, a word written into an empty FIFO is on `rd_data` with `rd_stat`=1 after the second edge following its write, with no read strobe. Each edge that sees `rd_en` with `rd_stat`=1 presents the next word, or drops `rd_stat` when none is left.
- R7: A rewind (`rewind`=1 with `wr_en`=0) makes later reads restart at array location zero. They return every word written since the last reset, in order, provided fewer than DEPTH writes have occurred. In fall-through mode, word zero is valid again after one further edge.
- R8: A rewind requested while `wr_en` is high is ignored; the write still takes place and reading continues where it was.
- R9: A write while the array is full and a read while the FIFO is empty are ignored: nothing is stored, no pointer moves, and `rd_data` keeps its value.
- R10: In fall-through mode, `wr_stat`=1 while the array has a free slot. Total capacity is DEPTH+1 words, because one word sits in the output stage, so `wr_stat` falls after the (DEPTH+1)th back-to-back write into an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| mrst | input | 1 | Master reset, synchronous, active high; samples `mode_sel` |
| prst | input | 1 | Partial reset, synchronous, active high; keeps mode |
| mode_sel | input | 1 | Mode strap: 1 = fall-through, 0 = standard |
| rewind | input | 1 | Retransmit request: restart reading at location zero |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Word to store |
| wr_stat | output | 1 | Full (standard) or space available (fall-through) |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Output register |
| rd_stat | output | 1 | Empty (standard) or data valid (fall-through) |

## Verification
Rewind and write can be requested in the same cycle. The rule is that the write wins and the rewind is dropped. The bench provokes this by raising `rewind` together with a write in the middle of a partly read sequence. It then judges the outcome from the next read: it must return the word after the last one delivered, not word zero. A following read sequence then confirms that the concurrent write was stored. The same sequence is repeated with `wr_en` low, where replay from location zero is expected, in both standard and fall-through modes.

// File: rtl/fifo2m_pkg.sv
package fifo2m_pkg;

    typedef enum logic {
        RD_STANDARD = 1'b0,
        RD_FALLTHRU = 1'b1
    } rd_mode_e;

    // Commands for the pointer / occupancy unit
    typedef struct packed {
        logic clear;
        logic push;
        logic pop;
        logic rewind;
    } ptr_cmd_t;

    // Commands for the output register stage
    typedef struct packed {
        logic clear;
        logic load;
        logic drop;
    } out_cmd_t;

    function automatic logic is_fallthru(rd_mode_e m);
        return m == RD_FALLTHRU;
    endfunction

endpackage

// File: rtl/fifo2m_mode.sv
module fifo2m_mode
    import fifo2m_pkg::*;
(
    input  logic     clk,
    input  logic     mrst,
    input  logic     mode_sel,
    output rd_mode_e mode
);
    always_ff @(posedge clk) begin
        if (mrst)
            mode <= mode_sel ? RD_FALLTHRU : RD_STANDARD;
    end
endmodule

// File: rtl/fifo2m_ptrs.sv
module fifo2m_ptrs
    import fifo2m_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  ptr_cmd_t      cmd,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] count
);
    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (cmd.clear) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (cmd.push)
                wptr <= step(wptr);
            if (cmd.rewind) begin
                rptr  <= '0;
                count <= CW'(wptr);
            end else begin
                if (cmd.pop)
                    rptr <= step(rptr);
                case ({cmd.push, cmd.pop})
                    2'b10:   count <= count + 1'b1;
                    2'b01:   count <= count - 1'b1;
                    default: count <= count;
                endcase
            end
        end
    end
endmodule

// File: rtl/fifo2m_store.sv
module fifo2m_store #(
    parameter int DW    = 18,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (we && waddr == AW'(g))
                cells[g] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/fifo2m_outreg.sv
module fifo2m_outreg
    import fifo2m_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  out_cmd_t      cmd,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          valid
);
    always_ff @(posedge clk) begin
        if (cmd.clear) begin
            dout  <= '0;
            valid <= 1'b0;
        end else if (cmd.load) begin
            dout  <= din;
            valid <= 1'b1;
        end else if (cmd.drop) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
    import fifo2m_pkg::*;
#(
    parameter int DW    = 18,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          mode_sel,
    input  logic          rewind,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_stat,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_stat
);
    rd_mode_e      mode_q;
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic [DW-1:0] head;
    logic          out_valid;
    logic          clr, arr_full, arr_empty, ft;
    logic          rew_go, wr_go, rd_go, ft_pop, ft_drop;
    ptr_cmd_t      pcmd;
    out_cmd_t      ocmd;

    fifo2m_mode u_mode (
        .clk      (clk),
        .mrst     (mrst),
        .mode_sel (mode_sel),
        .mode     (mode_q)
    );

    assign clr       = mrst | prst;
    assign ft        = is_fallthru(mode_q);
    assign arr_full  = (count == CW'(DEPTH));
    assign arr_empty = (count == '0);

    // Rewind only while no write is being presented
    assign rew_go  = rewind & ~wr_en & ~clr;
    assign wr_go   = wr_en & ~arr_full & ~clr;
    // Standard mode: strobe-driven fetch
    assign rd_go   = ~ft & rd_en & ~arr_empty & ~clr & ~rew_go;
    // Fall-through mode: fetch whenever the output slot is free or being consumed
    assign ft_pop  = ft & ~arr_empty & (~out_valid | rd_en) & ~clr & ~rew_go;
    assign ft_drop = ft & ((rd_en & out_valid & arr_empty) | rew_go);

    always_comb begin
        pcmd        = '0;
        pcmd.clear  = clr;
        pcmd.push   = wr_go;
        pcmd.pop    = rd_go | ft_pop;
        pcmd.rewind = rew_go;
        ocmd        = '0;
        ocmd.clear  = clr;
        ocmd.load   = rd_go | ft_pop;
        ocmd.drop   = ft_drop;
    end

    fifo2m_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk   (clk),
        .cmd   (pcmd),
        .wptr  (wptr),
        .rptr  (rptr),
        .count (count)
    );

    fifo2m_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (wr_go),
        .waddr (wptr),
        .wdata (wr_data),
        .raddr (rptr),
        .rdata (head)
    );

    fifo2m_outreg #(.DW(DW)) u_out (
        .clk   (clk),
        .cmd   (ocmd),
        .din   (head),
        .dout  (rd_data),
        .valid (out_valid)
    );

    assign wr_stat = ft ? ~arr_full : arr_full;
    assign rd_stat = ft ? out_valid : arr_empty;
endmodule

// File: rtl/fifo2m_checker.sv
module fifo2m_checker
    import fifo2m_pkg::*;
#(
    parameter int DW    = 18,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          mrst,
    input logic          prst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          rewind,
    input logic          rd_stat,
    input rd_mode_e      mode_q,
    input logic [AW-1:0] wptr,
    input logic [AW-1:0] rptr,
    input logic [CW-1:0] count,
    input logic [DW-1:0] rd_data
);
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (mrst)
        !mrst |=> $stable(mode_q)); // R2

    AST_PARTIAL_CLEAR: assert property (@(posedge clk) disable iff (mrst)
        prst |=> (wptr == '0 && rptr == '0 && count == '0 && rd_data == '0)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (mrst)
        count <= CW'(DEPTH)); // R9

    AST_FULL_WPTR_HOLD: assert property (@(posedge clk) disable iff (mrst)
        (!prst && count == CW'(DEPTH)) |=> wptr == $past(wptr)); // R9

    AST_EMPTY_RPTR_HOLD: assert property (@(posedge clk) disable iff (mrst)
        (!prst && !rewind && count == '0) |=> rptr == $past(rptr)); // R9

    AST_REWIND_HOME: assert property (@(posedge clk) disable iff (mrst)
        (!prst && rewind && !wr_en) |=> rptr == '0); // R7

    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (mrst)
        (!prst && !rewind && mode_q == RD_FALLTHRU && !rd_stat && count != '0)
        |=> rd_stat); // R6

    AST_STD_READ_ADVANCES: assert property (@(posedge clk) disable iff (mrst)
        (!prst && !rewind && mode_q == RD_STANDARD && rd_en && count != '0)
        |=> rptr != $past(rptr)); // R5
endmodule

bind dual_mode_fifo fifo2m_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .mrst    (mrst),
    .prst    (prst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rewind  (rewind),
    .rd_stat (rd_stat),
    .mode_q  (mode_q),
    .wptr    (wptr),
    .rptr    (rptr),
    .count   (count),
    .rd_data (rd_data)
);

// File: tb/tb_dual_mode_fifo.sv
module tb_dual_mode_fifo;
    localparam int DW    = 18;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          mrst = 1'b1, prst = 1'b0, mode_sel = 1'b0, rewind = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_stat, rd_stat;
    logic [DW-1:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dual_mode_fifo #(.DW(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .mrst(mrst), .prst(prst), .mode_sel(mode_sel),
        .rewind(rewind), .wr_en(wr_en), .wr_data(wr_data), .wr_stat(wr_stat),
        .rd_en(rd_en), .rd_data(rd_data), .rd_stat(rd_stat)
    );

    function automatic logic [DW-1:0] val(int i);
        return DW'((i * 7919 + 3) ^ (i << 11));
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of stimulus; on return the outputs reflect that edge.
    task automatic cyc(logic w, logic [DW-1:0] d, logic r, logic rw, logic pr);
        wr_en = w; wr_data = d; rd_en = r; rewind = rw; prst = pr;
        @(posedge clk);
        #5;
        wr_en = 1'b0; rd_en = 1'b0; rewind = 1'b0; prst = 1'b0;
    endtask

    task automatic master_reset(logic sel);
        mode_sel = sel; mrst = 1'b1;
        @(posedge clk); @(posedge clk);
        #5;
        mrst = 1'b0; mode_sel = ~sel;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // ---------------- standard mode ----------------
        master_reset(1'b0);
        check("R1 data", rd_data, '0);
        check("R1 std empty", DW'(rd_stat), 1);
        check("R1 std not full", DW'(wr_stat), 0);

        for (int i = 0; i < DEPTH; i++) begin
            check("R4 not full before fill", DW'(wr_stat), 0);
            cyc(1, val(i), 0, 0, 0);
        end
        check("R4 full", DW'(wr_stat), 1);
        check("R4 not empty", DW'(rd_stat), 0);
        check("R5 no read keeps output", rd_data, '0);
        cyc(1, '1, 0, 0, 0); // R9 write while full
        check("R9 still full", DW'(wr_stat), 1);
        check("R2 mode held std", DW'(rd_stat), 0);

        for (int i = 0; i < DEPTH; i++) begin
            cyc(0, '0, 1, 0, 0);
            check("R5 std read order", rd_data, val(i));
        end
        check("R4 empty after drain", DW'(rd_stat), 1);
        cyc(0, '0, 1, 0, 0); // R9 read while empty
        check("R9 empty read holds data", rd_data, val(DEPTH - 1));
        check("R9 still empty", DW'(rd_stat), 1);

        // partial reset keeps standard mode
        cyc(0, '0, 0, 0, 1);
        check("R3 data cleared", rd_data, '0);
        check("R3 std empty polarity", DW'(rd_stat), 1);
        check("R3 std full polarity", DW'(wr_stat), 0);

        for (int i = 0; i < 5; i++) cyc(1, val(20 + i), 0, 0, 0);
        cyc(0, '0, 1, 0, 0);
        check("R5 read 20", rd_data, val(20));
        cyc(0, '0, 1, 0, 0);
        check("R5 read 21", rd_data, val(21));
        // rewind together with a write: rewind dropped
        cyc(1, val(25), 0, 1, 0);
        cyc(0, '0, 1, 0, 0);
        check("R8 rewind ignored during write", rd_data, val(22));
        // real rewind
        cyc(0, '0, 0, 1, 0);
        for (int i = 0; i < 6; i++) begin
            cyc(0, '0, 1, 0, 0);
            check("R7 std replay", rd_data, val(20 + i));
        end
        check("R7 replay ends empty", DW'(rd_stat), 1);

        // ---------------- fall-through mode ----------------
        master_reset(1'b1);
        check("R1 ft data", rd_data, '0);
        check("R1 ft not valid", DW'(rd_stat), 0);
        check("R2 ft ready polarity", DW'(wr_stat), 1);

        cyc(1, val(40), 0, 0, 0);
        cyc(0, '0, 0, 0, 0);
        check("R6 fall-through valid", DW'(rd_stat), 1);
        check("R6 fall-through data", rd_data, val(40));
        cyc(0, '0, 1, 0, 0);
        check("R6 last read drops valid", DW'(rd_stat), 0);

        for (int i = 0; i <= DEPTH; i++) begin
            check("R10 ready during fill", DW'(wr_stat), 1);
            cyc(1, val(50 + i), 0, 0, 0);
        end
        check("R10 ready drops at DEPTH+1", DW'(wr_stat), 0);
        cyc(1, '1, 0, 0, 0); // R9 write while full
        for (int i = 0; i <= DEPTH; i++) begin
            check("R6 ft valid", DW'(rd_stat), 1);
            check("R6 ft head", rd_data, val(50 + i));
            cyc(0, '0, 1, 0, 0);
        end
        check("R9 ft overflow word absent", DW'(rd_stat), 0);
        cyc(0, '0, 1, 0, 0); // read while empty
        check("R9 ft empty read holds data", rd_data, val(50 + DEPTH));

        // partial reset keeps fall-through mode
        cyc(0, '0, 0, 0, 1);
        check("R3 ft data cleared", rd_data, '0);
        check("R3 ft ready polarity", DW'(wr_stat), 1);
        check("R3 ft not valid", DW'(rd_stat), 0);

        for (int i = 0; i < 3; i++) cyc(1, val(60 + i), 0, 0, 0);
        cyc(0, '0, 0, 0, 0);
        check("R6 ft head after writes", rd_data, val(60));
        cyc(0, '0, 1, 0, 0);
        check("R6 ft advance", rd_data, val(61));
        cyc(0, '0, 0, 1, 0);
        cyc(0, '0, 0, 0, 0);
        check("R7 ft rewind valid", DW'(rd_stat), 1);
        check("R7 ft rewind word0", rd_data, val(60));
        for (int i = 1; i < 3; i++) begin
            cyc(0, '0, 1, 0, 0);
            check("R7 ft replay", rd_data, val(60 + i));
        end
        cyc(0, '0, 1, 0, 0);
        check("R7 ft replay ends", DW'(rd_stat), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule